// File: doc/BRIEF.md
# Single-Instrument Limit Order Book

This block keeps the resting book of one instrument. It accepts two kinds of command: an add, which carries an order id, a price, a side and a quantity, and a cancel, which carries only an order id. After each command it reports the highest bid price and the lowest ask price, each with its own valid bit, and it advances an 8-bit sequence number.

Resting quantity is kept as a total for each price level and each side, in a price ladder held in on-chip RAM. A cancel names only the order id, so the block also keeps an open-addressed hash table. For each live order id that table stores the side, the price and the quantity. A cancel looks up its id by linear probing, which takes one read per cycle. It then takes the order's quantity away from its level. When the best level on a side becomes empty, the block walks the ladder toward worse prices, one level per cycle, until it finds the next non-empty level.

Commands enter through a valid/ready handshake. The upstream source raises `cmd_valid` and holds every command field steady until it sees `cmd_ready` high at a rising edge. The block takes in one command at a time. It drops `cmd_ready` for the whole time a probe, update or rescan runs, which is the only way it applies back-pressure. Results come out as a one-cycle `upd_valid` pulse. The result pins are not back-pressured, and they hold their values between pulses.

Top module: `lob_book`

## Requirements
- R1: `cmd_ready` is high when the block is idle. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the next cycle until the cycle in which `upd_valid` pulses, and the block takes no other command in that time.
- R2: An add (`cmd_op`=0) whose quantity is non-zero and whose id is not live rests the order. The side is bid when `cmd_side`=0 and ask when `cmd_side`=1. The best bid becomes the highest price that holds resting bid quantity, and the best ask becomes the lowest price that holds resting ask quantity. The valid bit of a side is set while that side holds resting quantity.
- R3: A cancel (`cmd_op`=1) of a live id removes the whole quantity of that order from its level, using only the id. Other orders at the same level keep the level and the best price where they were.
- R4: When a cancel empties the best level of a side, the best price of that side moves to the nearest non-empty level in the worse direction: down for bids, up for asks. If that side holds nothing any more, it reports price 0 with its valid bit cleared.
- R5: Four kinds of command are rejected: a cancel of an id that is not live, an add of an id that is already live, an add with quantity 0, and an add while `2**HASH_BITS` orders are live. A rejected command raises `err` together with its `upd_valid` pulse and leaves the book as it was.
- R6: Every command, accepted or rejected, ends with `upd_valid` high for exactly one cycle. In that cycle `seq_num` has advanced by 1 modulo 256. The best prices and their valid bits change only in a cycle where `upd_valid` is high.
- R7: After reset `cmd_ready` is 1, the best prices and `seq_num` are 0, and both valid bits and `err` are 0.
- R8: The home slot of an id is the XOR of its consecutive `HASH_BITS`-bit chunks, which are 4-bit nibbles with the defaults. Ids that share a home slot are all kept, and a cancelled slot can be used again. Any mix of collisions holds up to `2**HASH_BITS` live orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 1 | 0 add, 1 cancel |
| cmd_id | input | ID_W | Order id |
| cmd_price | input | PX_W | Limit price, add only |
| cmd_side | input | 1 | 0 bid, 1 ask, add only |
| cmd_qty | input | QTY_W | Quantity, add only |
| upd_valid | output | 1 | One-cycle pulse when a command completes |
| err | output | 1 | Command was rejected, valid with upd_valid |
| best_bid | output | PX_W | Highest resting bid price |
| bid_ok | output | 1 | Bid side holds resting quantity |
| best_ask | output | PX_W | Lowest resting ask price |
| ask_ok | output | 1 | Ask side holds resting quantity |
| seq_num | output | 8 | Count of completed commands |

## Verification
The hardest case to reach from the ports is a cancel whose probe has to pass tombstones and colliding live entries before it finds its id, or before it concludes that the id is absent. Close behind it is an add that must reuse a freed slot in a table that is nearly full. The stimulus draws ids from a small pool, built so that the XOR fold of their nibbles lands on only 16 slots. Random add/cancel runs therefore keep the table crowded with collisions and tombstones. Directed sequences build a chain of three colliding ids, cancel the middle one, then fill the table to capacity and overflow it. Narrow bands of prices force rescans that run across empty levels all the way to both ends of the ladder.

// File: rtl/lob_pkg.sv
package lob_pkg;
  typedef enum logic [1:0] {SLOT_EMPTY = 2'd0, SLOT_LIVE = 2'd1, SLOT_GONE = 2'd2} slot_st_t;
  typedef enum logic [2:0] {S_IDLE, S_PROBE, S_INS, S_DEL, S_SCAN} fsm_t;
  localparam logic OP_ADD = 1'b0;
  localparam logic OP_CAN = 1'b1;
endpackage

// File: rtl/lob_hash_mem.sv
module lob_hash_mem
  import lob_pkg::*;
#(
  parameter int ID_W      = 16,
  parameter int PX_W      = 6,
  parameter int QTY_W     = 8,
  parameter int HASH_BITS = 4,
  localparam int DEPTH    = 1 << HASH_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [HASH_BITS-1:0] rd_idx,
  output slot_st_t             rd_st,
  output logic [ID_W-1:0]      rd_id,
  output logic                 rd_side,
  output logic [PX_W-1:0]      rd_px,
  output logic [QTY_W-1:0]     rd_qty,
  input  logic                 wr_en,
  input  logic [HASH_BITS-1:0] wr_idx,
  input  slot_st_t             wr_st,
  input  logic [ID_W-1:0]      wr_id,
  input  logic                 wr_side,
  input  logic [PX_W-1:0]      wr_px,
  input  logic [QTY_W-1:0]     wr_qty
);
  slot_st_t         st_q   [DEPTH];
  logic [ID_W-1:0]  id_q   [DEPTH];
  logic             side_q [DEPTH];
  logic [PX_W-1:0]  px_q   [DEPTH];
  logic [QTY_W-1:0] qty_q  [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= SLOT_EMPTY;
    end else if (wr_en) begin
      st_q[wr_idx]   <= wr_st;
      id_q[wr_idx]   <= wr_id;
      side_q[wr_idx] <= wr_side;
      px_q[wr_idx]   <= wr_px;
      qty_q[wr_idx]  <= wr_qty;
    end
  end

  assign rd_st   = st_q[rd_idx];
  assign rd_id   = id_q[rd_idx];
  assign rd_side = side_q[rd_idx];
  assign rd_px   = px_q[rd_idx];
  assign rd_qty  = qty_q[rd_idx];

  // R8: an insert never overwrites a slot that still holds a live order
  a_r8_no_live_overwrite: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_st == SLOT_LIVE) |-> (st_q[wr_idx] != SLOT_LIVE));
endmodule

// File: rtl/lob_ladder.sv
module lob_ladder #(
  parameter int PX_W  = 6,
  parameter int LQ_W  = 12,
  localparam int NLV  = 1 << PX_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_side,
  input  logic [PX_W-1:0] rd_px,
  output logic [LQ_W-1:0] rd_q,
  input  logic            wr_en,
  input  logic            wr_side,
  input  logic [PX_W-1:0] wr_px,
  input  logic [LQ_W-1:0] wr_q
);
  logic [LQ_W-1:0] lvl_bid [NLV];
  logic [LQ_W-1:0] lvl_ask [NLV];

  for (genvar s = 0; s < 2; s++) begin : g_side
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < NLV; i++) begin
          if (s == 0) lvl_bid[i] <= '0;
          else        lvl_ask[i] <= '0;
        end
      end else if (wr_en && wr_side == 1'(s)) begin
        if (s == 0) lvl_bid[wr_px] <= wr_q;
        else        lvl_ask[wr_px] <= wr_q;
      end
    end
  end

  assign rd_q = rd_side ? lvl_ask[rd_px] : lvl_bid[rd_px];
endmodule

// File: rtl/lob_book.sv
module lob_book
  import lob_pkg::*;
#(
  parameter int ID_W      = 16,
  parameter int PX_W      = 6,
  parameter int QTY_W     = 8,
  parameter int HASH_BITS = 4,
  localparam int DEPTH    = 1 << HASH_BITS,
  localparam int LQ_W     = QTY_W + HASH_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_op,
  input  logic [ID_W-1:0]  cmd_id,
  input  logic [PX_W-1:0]  cmd_price,
  input  logic             cmd_side,
  input  logic [QTY_W-1:0] cmd_qty,
  output logic             upd_valid,
  output logic             err,
  output logic [PX_W-1:0]  best_bid,
  output logic             bid_ok,
  output logic [PX_W-1:0]  best_ask,
  output logic             ask_ok,
  output logic [7:0]       seq_num
);
  localparam logic [PX_W-1:0]      PX_MAX  = '1;
  localparam logic [HASH_BITS-1:0] CNT_END = HASH_BITS'(DEPTH - 1);

  function automatic logic [HASH_BITS-1:0] home_slot(input logic [ID_W-1:0] v);
    logic [HASH_BITS-1:0] h;
    h = '0;
    for (int i = 0; i < ID_W; i++) h[i % HASH_BITS] ^= v[i];
    return h;
  endfunction

  fsm_t                 state;
  logic                 c_op, c_side;
  logic [ID_W-1:0]      c_id;
  logic [PX_W-1:0]      c_px;
  logic [QTY_W-1:0]     c_qty;
  logic [HASH_BITS-1:0] p_idx, p_cnt, ff_idx;
  logic                 ff_v;
  logic [PX_W-1:0]      scan_px;
  logic                 scan_side;

  slot_st_t             h_st;
  logic [ID_W-1:0]      h_id;
  logic                 h_side;
  logic [PX_W-1:0]      h_px;
  logic [QTY_W-1:0]     h_qty;
  logic                 hw_en;
  slot_st_t             hw_st;

  logic                 l_side, lw_en;
  logic [PX_W-1:0]      l_px;
  logic [LQ_W-1:0]      l_q, lw_q;

  lob_hash_mem #(.ID_W(ID_W), .PX_W(PX_W), .QTY_W(QTY_W), .HASH_BITS(HASH_BITS)) u_hash (
    .clk(clk), .rst(rst), .rd_idx(p_idx),
    .rd_st(h_st), .rd_id(h_id), .rd_side(h_side), .rd_px(h_px), .rd_qty(h_qty),
    .wr_en(hw_en), .wr_idx(p_idx), .wr_st(hw_st), .wr_id(c_id),
    .wr_side(c_side), .wr_px(c_px), .wr_qty(c_qty));

  lob_ladder #(.PX_W(PX_W), .LQ_W(LQ_W)) u_ladder (
    .clk(clk), .rst(rst), .rd_side(l_side), .rd_px(l_px), .rd_q(l_q),
    .wr_en(lw_en), .wr_side(l_side), .wr_px(l_px), .wr_q(lw_q));

  // probe decisions
  logic hit, stop, free_here, have_free;
  logic [HASH_BITS-1:0] cand;
  assign hit       = (h_st == SLOT_LIVE) && (h_id == c_id);
  assign stop      = (h_st == SLOT_EMPTY) || (p_cnt == CNT_END);
  assign free_here = (h_st != SLOT_LIVE);
  assign have_free = ff_v || free_here;
  assign cand      = ff_v ? ff_idx : p_idx;

  // scan step
  logic [PX_W-1:0] scan_nxt;
  logic            scan_edge;
  assign scan_nxt  = scan_side ? scan_px + 1'b1 : scan_px - 1'b1;
  assign scan_edge = scan_side ? (scan_px == PX_MAX) : (scan_px == '0);

  logic [LQ_W-1:0] del_q;
  assign del_q = l_q - LQ_W'(h_qty);

  always_comb begin
    l_side = c_side;
    l_px   = c_px;
    lw_en  = 1'b0;
    lw_q   = l_q + LQ_W'(c_qty);
    hw_en  = 1'b0;
    hw_st  = SLOT_LIVE;
    case (state)
      S_INS: begin lw_en = 1'b1; hw_en = 1'b1; end
      S_DEL: begin
        l_side = h_side; l_px = h_px; lw_q = del_q;
        lw_en = 1'b1; hw_en = 1'b1; hw_st = SLOT_GONE;
      end
      S_SCAN: begin l_side = scan_side; l_px = scan_nxt; end
      default: ;
    endcase
  end

  assign cmd_ready = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;  upd_valid <= 1'b0; err <= 1'b0; seq_num <= '0;
      best_bid <= '0; bid_ok <= 1'b0; best_ask <= '0; ask_ok <= 1'b0;
      c_op <= 1'b0; c_side <= 1'b0; c_id <= '0; c_px <= '0; c_qty <= '0;
      p_idx <= '0; p_cnt <= '0; ff_idx <= '0; ff_v <= 1'b0;
      scan_px <= '0; scan_side <= 1'b0;
    end else begin
      upd_valid <= 1'b0;
      err       <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          c_op <= cmd_op; c_id <= cmd_id; c_px <= cmd_price;
          c_side <= cmd_side; c_qty <= cmd_qty;
          p_idx <= home_slot(cmd_id); p_cnt <= '0; ff_v <= 1'b0;
          state <= S_PROBE;
        end
        S_PROBE: begin
          if (free_here && !ff_v) begin ff_v <= 1'b1; ff_idx <= p_idx; end
          if (hit || stop) begin
            if (c_op == OP_CAN) begin
              if (hit) state <= S_DEL;
              else begin
                state <= S_IDLE; upd_valid <= 1'b1; err <= 1'b1; seq_num <= seq_num + 8'd1;
              end
            end else if (hit || c_qty == '0 || !have_free) begin
              state <= S_IDLE; upd_valid <= 1'b1; err <= 1'b1; seq_num <= seq_num + 8'd1;
            end else begin
              p_idx <= cand; state <= S_INS;
            end
          end else begin
            p_idx <= p_idx + 1'b1; p_cnt <= p_cnt + 1'b1;
          end
        end
        S_INS: begin
          if (!c_side && (!bid_ok || c_px > best_bid)) begin best_bid <= c_px; bid_ok <= 1'b1; end
          if ( c_side && (!ask_ok || c_px < best_ask)) begin best_ask <= c_px; ask_ok <= 1'b1; end
          state <= S_IDLE; upd_valid <= 1'b1; seq_num <= seq_num + 8'd1;
        end
        S_DEL: begin
          if (del_q == '0 && h_px == (h_side ? best_ask : best_bid)) begin
            scan_px <= h_px; scan_side <= h_side; state <= S_SCAN;
          end else begin
            state <= S_IDLE; upd_valid <= 1'b1; seq_num <= seq_num + 8'd1;
          end
        end
        S_SCAN: begin
          if (scan_edge || l_q != '0) begin
            if (scan_side) begin best_ask <= scan_edge ? '0 : scan_nxt; ask_ok <= !scan_edge; end
            else           begin best_bid <= scan_edge ? '0 : scan_nxt; bid_ok <= !scan_edge; end
            state <= S_IDLE; upd_valid <= 1'b1; seq_num <= seq_num + 8'd1;
          end else begin
            scan_px <= scan_nxt;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: once a command is taken, no second one is offered acceptance
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  // R6: completion pulse carries an advanced sequence number
  a_r6_seq_step: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> (seq_num == $past(seq_num) + 8'd1));
  // R6: published book changes only with a completion pulse
  a_r6_book_moves_with_upd: assert property (@(posedge clk) disable iff (rst)
    !$stable({best_bid, bid_ok, best_ask, ask_ok}) |-> upd_valid);
  // R5: rejection is only reported with a completion
  a_r5_err_with_upd: assert property (@(posedge clk) disable iff (rst)
    err |-> upd_valid);
  // R4: an empty side reports price zero
  a_r4_bid_empty_zero: assert property (@(posedge clk) disable iff (rst)
    !bid_ok |-> (best_bid == '0));
  a_r4_ask_empty_zero: assert property (@(posedge clk) disable iff (rst)
    !ask_ok |-> (best_ask == '0));
endmodule

// File: tb/test_lob_book.sv
module test_lob_book;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_op = 1'b0, cmd_side = 1'b0;
  logic [15:0] cmd_id = '0;
  logic [5:0]  cmd_price = '0;
  logic [7:0]  cmd_qty = '0;
  logic cmd_ready, upd_valid, err, bid_ok, ask_ok;
  logic [5:0] best_bid, best_ask;
  logic [7:0] seq_num;

  always #10 clk = ~clk;

  lob_book i_lob_book (.clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_price(cmd_price), .cmd_side(cmd_side),
    .cmd_qty(cmd_qty), .upd_valid(upd_valid), .err(err), .best_bid(best_bid),
    .bid_ok(bid_ok), .best_ask(best_ask), .ask_ok(ask_ok), .seq_num(seq_num));

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // reference model: unordered set of live orders
  bit        m_live [DEPTH];
  logic [15:0] m_id [DEPTH];
  logic [5:0]  m_px [DEPTH];
  bit        m_side [DEPTH];
  logic [7:0] exp_seq = '0;
  int unsigned rng = 32'h1234_5678;

  function automatic int unsigned nxt_rand();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  function automatic int m_find(input logic [15:0] id);
    for (int i = 0; i < DEPTH; i++) if (m_live[i] && m_id[i] == id) return i;
    return -1;
  endfunction

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < DEPTH; i++) if (m_live[i]) c++;
    return c;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input bit op, input logic [15:0] id, input logic [5:0] px,
                       input bit sd, input logic [7:0] q);
    bit e_err;
    int k;
    logic [5:0] ebb, eba;
    bit ebo, eao;
    k = m_find(id);
    if (op == 1'b0) begin
      e_err = (k >= 0) || (q == 0) || (m_count() == DEPTH);
      if (!e_err) begin
        for (int i = 0; i < DEPTH; i++) if (!m_live[i]) begin
          m_live[i] = 1; m_id[i] = id; m_px[i] = px; m_side[i] = sd; break;
        end
      end
    end else begin
      e_err = (k < 0);
      if (!e_err) m_live[k] = 0;
    end
    ebb = '0; eba = '0; ebo = 0; eao = 0;
    for (int i = 0; i < DEPTH; i++) if (m_live[i]) begin
      if (!m_side[i] && (!ebo || m_px[i] > ebb)) begin ebb = m_px[i]; ebo = 1; end
      if ( m_side[i] && (!eao || m_px[i] < eba)) begin eba = m_px[i]; eao = 1; end
    end
    exp_seq = exp_seq + 8'd1;

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_id = id; cmd_price = px; cmd_side = sd; cmd_qty = q;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R1 ready low while busy", 16'(cmd_ready), 16'd0);
    while (!upd_valid) @(negedge clk);
    chk(op ? "R5/R3 cancel err flag" : "R5/R2 add err flag", 16'(err), 16'(e_err));
    chk("R2/R4 best bid", 16'(best_bid), 16'(ebb));
    chk("R2/R4 bid valid", 16'(bid_ok), 16'(ebo));
    chk("R2/R4 best ask", 16'(best_ask), 16'(eba));
    chk("R2/R4 ask valid", 16'(ask_ok), 16'(eao));
    chk("R6 sequence number", 16'(seq_num), 16'(exp_seq));
    chk("R1 ready back when done", 16'(cmd_ready), 16'd1);
    @(negedge clk);
    chk("R6 single-cycle pulse", 16'(upd_valid), 16'd0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_live[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state
    chk("R7 ready", 16'(cmd_ready), 16'd1);
    chk("R7 best bid", 16'(best_bid), 16'd0);
    chk("R7 bid valid", 16'(bid_ok), 16'd0);
    chk("R7 ask valid", 16'(ask_ok), 16'd0);
    chk("R7 seq", 16'(seq_num), 16'd0);
    chk("R7 err", 16'(err), 16'd0);

    // R2, R3, R4: bid side rescan down to empty, ask side rescan up to empty
    issue(0, 16'h0100, 6'd10, 0, 8'd5);
    issue(0, 16'h0200, 6'd3,  0, 8'd2);
    issue(0, 16'h0300, 6'd10, 0, 8'd1);
    issue(1, 16'h0100, 6'd0,  0, 8'd0);   // R3: level 10 still holds 0x0300
    issue(1, 16'h0300, 6'd0,  0, 8'd0);   // R4: bid best falls to 3
    issue(1, 16'h0200, 6'd0,  0, 8'd0);   // R4: bid side empty
    issue(0, 16'h0400, 6'd63, 1, 8'd7);
    issue(0, 16'h0500, 6'd60, 1, 8'd7);
    issue(1, 16'h0500, 6'd0,  0, 8'd0);   // R4: ask best rises to 63
    issue(1, 16'h0400, 6'd0,  0, 8'd0);   // R4: ask empty at top edge
    // R5: rejections
    issue(1, 16'h7777, 6'd0,  0, 8'd0);
    issue(0, 16'h0600, 6'd9,  0, 8'd0);
    issue(0, 16'h0600, 6'd9,  0, 8'd4);
    issue(0, 16'h0600, 6'd8,  1, 8'd4);
    issue(1, 16'h0600, 6'd0,  0, 8'd0);
    // R8: three ids on home slot 3, cancel middle, find last past tombstone
    issue(0, 16'h0012, 6'd20, 0, 8'd1);
    issue(0, 16'h0021, 6'd21, 0, 8'd1);
    issue(0, 16'h0300, 6'd22, 1, 8'd1);
    issue(1, 16'h0021, 6'd0,  0, 8'd0);
    issue(0, 16'h0300, 6'd22, 1, 8'd1);   // R8: still found as duplicate
    issue(1, 16'h0300, 6'd0,  0, 8'd0);
    issue(0, 16'h0021, 6'd25, 0, 8'd2);   // R8: reuse freed slot
    // R5/R8: fill to capacity with colliding ids, then overflow
    for (int i = 0; i < DEPTH; i++) issue(0, 16'h1000 + 16'(i * 16'h0110), 6'(i + 1), i[0], 8'd1);
    for (int i = 0; i < 4; i++) issue(1, 16'h1000 + 16'(i * 16'h0110), 6'd0, 0, 8'd0);
    for (int i = 0; i < 6; i++) issue(0, 16'h2000 + 16'(i), 6'(40 + i), i[0], 8'd3);

    // random sweep over a crowded id pool and narrow price bands
    for (int n = 0; n < 1500; n++) begin
      int unsigned r;
      logic [15:0] id;
      r = nxt_rand();
      id = {8'h00, 4'(r >> 8), 1'b0, 3'(r >> 12)};
      if (r[0] && m_count() > 0 && r[1]) begin
        for (int i = 0; i < DEPTH; i++) begin
          int j;
          j = (i + int'(r >> 20)) % DEPTH;
          if (m_live[j]) begin id = m_id[j]; break; end
        end
        issue(1, id, 6'd0, 0, 8'd0);
      end else if (r[0]) begin
        issue(1, id, 6'd0, 0, 8'd0);
      end else begin
        logic [5:0] px;
        px = r[2] ? 6'(r >> 16) : (r[3] ? 6'(60 + (r >> 16) % 4) : 6'((r >> 16) % 4));
        issue(0, id, px, r[4], (r[7:5] == 0) ? 8'd0 : 8'(r >> 24));
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule